// File: doc/BRIEF.md
# Neuron Multiply-Accumulate Unit

This block forms the weighted sum of one artificial neuron. Each cycle it can take one signed data sample and one signed weight, multiply them in a pipelined multiplier, and add the product into an accumulator. The accumulator is wide enough that the configured number of products can never overflow it. A start-of-evaluation flag travels with the first term and restarts the sum. A capture flag travels with any term, normally the last one, and copies the sum into an output register. The sum seen by that register already includes the term that carries the flag. A one-cycle strobe marks every capture.

The accumulator feeds the output register through a narrowing stage, which is chosen by a parameter. The stage either passes the full sum through, or shifts away a set number of fraction bits and then fits the result into a smaller word. When the value does not fit, it keeps the low bits (wraparound) or clamps to the nearest representable limit (saturation). A sequencer upstream supplies data, weights and the three per-term flags. The memories, the activation function and the sequencing itself lie outside this block.

Top module: `neuron_mac`

## Requirements
- R1: Data, weight and product are two's complement. The product of a DATA_W-bit and a WGT_W-bit operand is sign-extended to the accumulator width before it is added.
- R2: The accumulator is $clog2(ACC_CNT) + DATA_W + WGT_W bits wide. Any ACC_CNT products, including the most positive (-2^(DATA_W-1) squared, 16384 at defaults) and the most negative, sum exactly.
- R3: A term with acc_clear and in_valid both high restarts the sum at that term's product. A term with acc_clear high and in_valid low restarts it at zero. The restart takes effect at the same pipeline position as the products.
- R4: The output register changes only when a term carrying load_en reaches the end of the pipeline. It then holds the sum including that term's product. In all other cycles out_data keeps its value.
- R5: out_valid is high for exactly one cycle per term that carries load_en. It rises MUL_LAT clock cycles after the edge that samples that term. Every term carrying load_en produces exactly one such strobe.
- R6: In the narrowing modes the sum is first shifted right arithmetically by DROP_LSB bits, which rounds toward minus infinity.
- R7: In wrap mode out_data is the low OUT_W bits of the shifted sum.
- R8: In saturation mode out_data is the shifted sum when that value fits in OUT_W signed bits. Otherwise out_data is 2^(OUT_W-1)-1 for positive values and -2^(OUT_W-1) for negative ones. With no narrowing, out_data is the full sum.
- R9: While rst_n is low, out_data, out_valid and the accumulator are zero.
- R10: Terms with in_valid low add nothing to the sum, whatever data_in and weight_in hold.
- R11: Evaluations may follow each other with no gap. A single term may carry both acc_clear and load_en, and it then yields exactly its own product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The term's data and weight take part in the sum |
| acc_clear | input | 1 | The term starts a new evaluation |
| load_en | input | 1 | Capture the sum after this term into the output register |
| data_in | input | DATA_W | Signed data sample |
| weight_in | input | WGT_W | Signed weight |
| out_data | output | OUT_W, or ACC_W with no narrowing | Captured and narrowed sum |
| out_valid | output | 1 | One-cycle strobe for each capture |

## Verification
Every capture is due exactly MUL_LAT cycles after the rising edge that samples the term carrying load_en. The driver stamps each expected sum with that due cycle when it pushes the sum into the scoreboard. The monitor samples on the falling edge and compares each strobe against the cycle stamp as well as the value. One stimulus stream drives three instances at the same time: saturating, wrapping and full width. The monitor checks that their strobes coincide. In every cycle without a strobe it also checks that the output held its value.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

    // How the accumulated sum is fitted to the output word
    typedef enum logic [1:0] {
        NARROW_NONE = 2'd0,   // full accumulator width reaches the output
        NARROW_WRAP = 2'd1,   // shift, then keep low bits
        NARROW_SAT  = 2'd2    // shift, then clamp to the signed range
    } narrow_mode_e;

    // Per-term control that rides alongside the product
    typedef struct packed {
        logic valid;
        logic clear;
        logic load;
    } term_tag_t;

endpackage

// File: rtl/nmac_mul_pipe.sv
module nmac_mul_pipe
    import nmac_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WGT_W  = 8,
    parameter int LAT    = 3,
    localparam int PROD_W = DATA_W + WGT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  term_tag_t         tag_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [WGT_W-1:0]  wgt_in,
    output term_tag_t         tag_out,
    output logic [PROD_W-1:0] prod_out
);

    typedef struct packed {
        term_tag_t [LAT-1:0]              tag;
        logic      [LAT-1:0][PROD_W-1:0]  prod;
    } pipe_t;

    pipe_t st_d, st_q;
    logic signed [PROD_W-1:0] raw_prod;

    always_comb begin
        raw_prod = PROD_W'($signed(data_in)) * PROD_W'($signed(wgt_in));
        st_d = st_q;
        st_d.tag[0]  = tag_in;
        st_d.prod[0] = raw_prod;
        for (int i = 1; i < LAT; i++) begin
            st_d.tag[i]  = st_q.tag[i-1];
            st_d.prod[i] = st_q.prod[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_out  = st_q.tag[LAT-1];
    assign prod_out = st_q.prod[LAT-1];

endmodule

// File: rtl/nmac_accum.sv
module nmac_accum
    import nmac_pkg::*;
#(
    parameter int PROD_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  term_tag_t         tag,
    input  logic [PROD_W-1:0] prod,
    output logic [ACC_W-1:0]  acc_next,
    output logic [ACC_W-1:0]  acc_q
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W-1:0] ext_prod;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] addend;

    always_comb begin
        ext_prod = ACC_W'($signed(prod));
        base     = tag.clear ? '0 : st_q.acc;
        addend   = tag.valid ? ext_prod : '0;
        st_d.acc = base + addend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_next = st_d.acc;
    assign acc_q    = st_q.acc;

endmodule

// File: rtl/nmac_narrow.sv
module nmac_narrow
    import nmac_pkg::*;
#(
    parameter int           ACC_W = 20,
    parameter int           OUT_W = 8,
    parameter int           DROP  = 6,
    parameter narrow_mode_e MODE  = NARROW_SAT,
    localparam int Y_W = (MODE == NARROW_NONE) ? ACC_W : OUT_W
) (
    input  logic [ACC_W-1:0] sum,
    output logic [Y_W-1:0]   y
);

    generate
        if (MODE == NARROW_NONE) begin : g_pass
            assign y = sum;
        end else begin : g_cut
            logic signed [ACC_W-1:0] sh;
            assign sh = $signed(sum) >>> DROP;

            if (MODE == NARROW_WRAP) begin : g_wrap
                assign y = sh[OUT_W-1:0];
            end else begin : g_sat
                logic [ACC_W-OUT_W:0] upper;
                logic                 fits;
                logic [OUT_W-1:0]     pos_lim;
                logic [OUT_W-1:0]     neg_lim;
                assign upper   = sh[ACC_W-1:OUT_W-1];
                assign fits    = (&upper) | ~(|upper);
                assign pos_lim = {1'b0, {(OUT_W-1){1'b1}}};
                assign neg_lim = {1'b1, {(OUT_W-1){1'b0}}};
                assign y = fits ? sh[OUT_W-1:0]
                                : (sh[ACC_W-1] ? neg_lim : pos_lim);
            end
        end
    endgenerate

endmodule

// File: rtl/neuron_mac.sv
module neuron_mac
    import nmac_pkg::*;
#(
    parameter int           DATA_W   = 8,
    parameter int           WGT_W    = 8,
    parameter int           MUL_LAT  = 3,
    parameter int           ACC_CNT  = 16,
    parameter int           OUT_W    = 8,
    parameter int           DROP_LSB = 6,
    parameter narrow_mode_e MODE     = NARROW_SAT,
    localparam int PROD_W    = DATA_W + WGT_W,
    localparam int ACC_W     = $clog2(ACC_CNT) + PROD_W,
    localparam int OUT_REG_W = (MODE == NARROW_NONE) ? ACC_W : OUT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 acc_clear,
    input  logic                 load_en,
    input  logic [DATA_W-1:0]    data_in,
    input  logic [WGT_W-1:0]     weight_in,
    output logic [OUT_REG_W-1:0] out_data,
    output logic                 out_valid
);

    term_tag_t             tag_in;
    term_tag_t             tag_p;
    logic [PROD_W-1:0]     prod_p;
    logic [ACC_W-1:0]      acc_next;
    logic [ACC_W-1:0]      acc_q;
    logic [OUT_REG_W-1:0]  narrowed;

    assign tag_in = '{valid: in_valid, clear: acc_clear, load: load_en};

    nmac_mul_pipe #(
        .DATA_W (DATA_W),
        .WGT_W  (WGT_W),
        .LAT    (MUL_LAT)
    ) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_in   (tag_in),
        .data_in  (data_in),
        .wgt_in   (weight_in),
        .tag_out  (tag_p),
        .prod_out (prod_p)
    );

    nmac_accum #(
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag      (tag_p),
        .prod     (prod_p),
        .acc_next (acc_next),
        .acc_q    (acc_q)
    );

    nmac_narrow #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .DROP  (DROP_LSB),
        .MODE  (MODE)
    ) u_narrow (
        .sum (acc_next),
        .y   (narrowed)
    );

    typedef struct packed {
        logic [OUT_REG_W-1:0] data;
        logic                 valid;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = tag_p.load;
        if (tag_p.load) begin
            st_d.data = narrowed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = st_q.data;
    assign out_valid = st_q.valid;

endmodule

// File: rtl/neuron_mac_chk.sv
module neuron_mac_chk
    import nmac_pkg::*;
#(
    parameter int           DATA_W   = 8,
    parameter int           WGT_W    = 8,
    parameter int           MUL_LAT  = 3,
    parameter int           ACC_CNT  = 16,
    parameter int           OUT_W    = 8,
    parameter int           DROP_LSB = 6,
    parameter narrow_mode_e MODE     = NARROW_SAT,
    localparam int PROD_W    = DATA_W + WGT_W,
    localparam int ACC_W     = $clog2(ACC_CNT) + PROD_W,
    localparam int OUT_REG_W = (MODE == NARROW_NONE) ? ACC_W : OUT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_en,
    input logic                 out_valid,
    input logic [OUT_REG_W-1:0] out_data,
    input logic [ACC_W-1:0]     acc_q,
    input logic [PROD_W-1:0]    prod_p,
    input logic                 tag_valid,
    input logic                 tag_clear
);

    // Independent record of when captures were requested
    logic [MUL_LAT-1:0] ld_line;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_line <= '0;
        end else begin
            ld_line[0] <= load_en;
            for (int i = 1; i < MUL_LAT; i++) begin
                ld_line[i] <= ld_line[i-1];
            end
        end
    end

    // R5: strobe follows the capture request by exactly MUL_LAT cycles
    a_r5_strobe_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        ld_line[MUL_LAT-1] |=> out_valid);
    a_r5_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_line[MUL_LAT-1] |=> !out_valid);

    // R4: output holds between captures
    a_r4_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R3: restart with a product, or at zero
    a_r3_restart_product: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_clear && tag_valid) |=> acc_q == ACC_W'($signed($past(prod_p))));
    a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_clear && !tag_valid) |=> acc_q == '0);

    // R10: idle terms leave the sum untouched
    a_r10_idle_no_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!tag_valid && !tag_clear) |=> $stable(acc_q));

    // R1: sign-extended product is added to the running sum
    a_r1_signed_add: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !tag_clear) |=>
            acc_q == $past(acc_q) + ACC_W'($signed($past(prod_p))));

    generate
        if (MODE != NARROW_NONE) begin : g_cut_chk
            logic signed [ACC_W-1:0] sh_chk;
            assign sh_chk = $signed(acc_q) >>> DROP_LSB;

            if (MODE == NARROW_WRAP) begin : g_wrap_chk
                // R7: low bits of the shifted sum
                a_r7_wrap_bits: assert property (@(posedge clk) disable iff (!rst_n)
                    out_valid |-> out_data == sh_chk[OUT_W-1:0]);
            end else begin : g_sat_chk
                logic signed [ACC_W-1:0] hi_lim;
                logic signed [ACC_W-1:0] lo_lim;
                assign hi_lim = ACC_W'((2 ** (OUT_W - 1)) - 1);
                assign lo_lim = -hi_lim - ACC_W'(1);
                // R8: clamp above and below, pass through inside the range
                a_r8_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && sh_chk > hi_lim) |-> out_data == OUT_W'(hi_lim));
                a_r8_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && sh_chk < lo_lim) |-> out_data == OUT_W'(lo_lim));
                a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && sh_chk <= hi_lim && sh_chk >= lo_lim)
                        |-> out_data == sh_chk[OUT_W-1:0]);
            end
        end
    endgenerate

endmodule

bind neuron_mac neuron_mac_chk #(
    .DATA_W   (DATA_W),
    .WGT_W    (WGT_W),
    .MUL_LAT  (MUL_LAT),
    .ACC_CNT  (ACC_CNT),
    .OUT_W    (OUT_W),
    .DROP_LSB (DROP_LSB),
    .MODE     (MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .out_valid (out_valid),
    .out_data  (out_data),
    .acc_q     (acc_q),
    .prod_p    (prod_p),
    .tag_valid (tag_p.valid),
    .tag_clear (tag_p.clear)
);

// File: tb/neuron_mac_tb.sv
module neuron_mac_tb;
    import nmac_pkg::*;

    localparam int DW   = 8;
    localparam int WW   = 8;
    localparam int LAT  = 3;
    localparam int CNT  = 16;
    localparam int OW   = 8;
    localparam int DROP = 6;
    localparam int ACCW = $clog2(CNT) + DW + WW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n     = 1'b1;
    logic          in_valid  = 1'b0;
    logic          acc_clear = 1'b0;
    logic          load_en   = 1'b0;
    logic [DW-1:0] data_in   = '0;
    logic [WW-1:0] weight_in = '0;

    logic [OW-1:0]   sat_out, wrap_out;
    logic [ACCW-1:0] full_out;
    logic            sat_v, wrap_v, full_v;

    neuron_mac #(.DATA_W(DW), .WGT_W(WW), .MUL_LAT(LAT), .ACC_CNT(CNT),
                 .OUT_W(OW), .DROP_LSB(DROP), .MODE(NARROW_SAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
        .load_en(load_en), .data_in(data_in), .weight_in(weight_in),
        .out_data(sat_out), .out_valid(sat_v));

    neuron_mac #(.DATA_W(DW), .WGT_W(WW), .MUL_LAT(LAT), .ACC_CNT(CNT),
                 .OUT_W(OW), .DROP_LSB(DROP), .MODE(NARROW_WRAP)) u_wrap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
        .load_en(load_en), .data_in(data_in), .weight_in(weight_in),
        .out_data(wrap_out), .out_valid(wrap_v));

    neuron_mac #(.DATA_W(DW), .WGT_W(WW), .MUL_LAT(LAT), .ACC_CNT(CNT),
                 .OUT_W(OW), .DROP_LSB(DROP), .MODE(NARROW_NONE)) u_full (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
        .load_en(load_en), .data_in(data_in), .weight_in(weight_in),
        .out_data(full_out), .out_valid(full_v));

    typedef struct {
        longint full;
        int     due;
    } exp_t;

    exp_t   sb[$];
    int     vectors = 0;
    int     fails   = 0;
    int     cyc     = 0;
    longint model   = 0;
    bit     mon_en  = 1'b0;
    logic [OW-1:0] prev_sat = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, longint act, longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: applies one term and pushes the expected capture
    task automatic feed(int d, int w, bit v, bit c, bit l);
        longint p;
        @(negedge clk);
        in_valid  = v;
        acc_clear = c;
        load_en   = l;
        data_in   = DW'(d);
        weight_in = WW'(w);
        p = v ? longint'(d) * longint'(w) : 0;
        model = c ? p : model + p;
        if (l) sb.push_back('{full: model, due: cyc + 1 + LAT});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++)
            feed(int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128, 0, 0, 0);
    endtask

    // Monitor: compares captures as they appear
    always @(negedge clk) begin
        if (mon_en) begin
            if (sat_v) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 strobe without request", 1, 0);
                end else begin
                    exp_t   e;
                    longint sh, sat_e;
                    e = sb.pop_front();
                    sh = e.full >>> DROP;
                    sat_e = (sh > 127) ? 127 : ((sh < -128) ? -128 : sh);
                    check(cyc == e.due, "R5 capture latency", cyc, e.due);
                    check(wrap_v && full_v, "R5 strobes coincide", {wrap_v, full_v}, 3);
                    check(longint'($signed(full_out)) == e.full, "R2 full-width sum",
                          longint'($signed(full_out)), e.full);
                    check(longint'($signed(sat_out)) == sat_e, "R8 saturated output",
                          longint'($signed(sat_out)), sat_e);
                    check(longint'(wrap_out) == (sh & 255), "R7 wrapped output",
                          longint'(wrap_out), sh & 255);
                end
            end else begin
                check(sat_out == prev_sat, "R4 output hold", sat_out, prev_sat);
                check(!wrap_v && !full_v, "R5 no stray strobe", {wrap_v, full_v}, 0);
            end
            prev_sat = sat_out;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(sat_out == 0 && !sat_v, "R9 reset saturating", sat_out, 0);
        check(wrap_out == 0 && !wrap_v, "R9 reset wrapping", wrap_out, 0);
        check(full_out == 0 && !full_v, "R9 reset full", full_out, 0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        idle(2);

        // R1 R6: small mixed-sign evaluation
        feed(3, 5, 1, 1, 0);
        feed(-2, 7, 1, 0, 0);
        feed(10, -4, 1, 0, 0);
        feed(1, 1, 1, 0, 1);
        idle(2);

        // R10: idle terms with garbage operands in the middle
        feed(100, 100, 1, 1, 0);
        feed(-128, -128, 0, 0, 0);
        feed(127, -128, 0, 0, 0);
        feed(-50, 60, 1, 0, 1);
        idle(1);

        // R2 R8: most positive sum over the full count
        for (int i = 0; i < CNT; i++)
            feed(-128, -128, 1, i == 0, i == CNT - 1);
        // R2 R8 R11: most negative sum, back to back
        for (int i = 0; i < CNT; i++)
            feed(-128, 127, 1, i == 0, i == CNT - 1);

        // R11: single-term evaluations back to back
        feed(9, 9, 1, 1, 1);
        feed(-7, 100, 1, 1, 1);
        feed(64, 1, 1, 1, 1);

        // R3: restart at zero after a partial sum
        feed(120, 120, 1, 1, 0);
        feed(120, 120, 1, 0, 0);
        feed(0, 0, 0, 1, 0);
        feed(20, 30, 1, 0, 0);
        feed(-5, 40, 1, 0, 1);
        idle(2);

        // R4: capture mid-evaluation, on an idle term, then at the end
        feed(50, 40, 1, 1, 0);
        feed(30, 30, 1, 0, 1);
        feed(77, 77, 0, 0, 1);
        feed(-90, 90, 1, 0, 0);
        feed(11, -12, 1, 0, 1);
        idle(3);

        // Mixed evaluations with gaps and varying length
        for (int e = 0; e < 60; e++) begin
            int n;
            n = 1 + int'($urandom_range(CNT - 1));
            for (int t = 0; t < n; t++) begin
                if ($urandom_range(3) == 0) idle(1);
                feed(int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
                     1, t == 0, t == n - 1);
            end
            if ($urandom_range(1) == 0) idle(int'($urandom_range(3)));
        end

        idle(LAT + 4);
        check(sb.size() == 0, "R5 every capture answered", sb.size(), 0);
        finish_run();
    end

endmodule